// File: doc/BRIEF.md
# Bus-Mapped FIFO Read Window

This block puts a receive FIFO behind a small window on a 16-bit memory-style bus, so that a DMA engine or a CPU can drain it by reading one fixed address again and again. In the wide configuration each queued entry is 32 bits. The entry is fetched as two 16-bit reads: the low half comes from the window's first half-word and the high half from the next one. The entry leaves the FIFO only when its high half is read, so a two-beat fetch never loses or skips data. In the narrow configuration entries are 16 bits, and each read of the window's first half-word returns one entry and removes it.

A producer fills the receive FIFO through a push port that shows when the FIFO is full. An occupancy output lets an external trigger source request a DMA burst once enough entries are waiting. The same window also has a transmit direction. Bus writes to a fixed address build entries and queue them for a consumer-side pop port. A status half-word holds sticky error flags, which software clears by writing ones.

Addresses are byte addresses. The window occupies 32 bytes starting at `BASE`, whose five lowest bits must be zero. Offsets: 0x0 receive low half (or the whole entry in narrow mode), 0x2 receive high half, 0x4 transmit low half, 0x6 transmit high half, 0x8 status. Status bit 0 is receive underflow, bit 1 is receive overflow and bit 2 is transmit overflow.

Top module: `fifo_read_window`

## Requirements
- R1: Reads of the receive high half at a fixed address return successive FIFO entries in first-in-first-out order, and each such read removes exactly one entry.
- R2: In wide mode, offset 0x0 returns bits 15:0 of the head entry and offset 0x2 returns bits 31:16 of the head entry.
- R3: A read of the receive low half (offset 0x0 in wide mode) changes no state: repeated low reads return the same value and leave the occupancy unchanged.
- R4: Read data is registered. It appears on `bus_rdata` at the first rising clock edge that samples `bus_cs` and `bus_rd` high, and it holds its value until the next read inside the window.
- R5: A read of receive data while the FIFO is empty returns 0, removes nothing and sets status bit 0.
- R6: `push_full` is high when the occupancy equals `DEPTH`. A push while the FIFO is full is dropped, even if a pop happens in the same cycle, and it sets status bit 1.
- R7: Offset 0x8 reads the status flags in bits 2:0. A write there clears each flag whose write-data bit is 1 and leaves the flags whose bit is 0.
- R8: `rx_level` equals the number of entries held in the receive FIFO.
- R9: An access is ignored when bits above bit 4 of its address differ from `BASE` or when its address is odd. Such an access leaves `bus_rdata` unchanged and pops nothing.
- R10: In wide mode, a write to offset 0x4 only stages the low half. A write to offset 0x6 queues {write data, staged low half} into the transmit FIFO. `tx_data` shows the transmit head and `tx_pop` removes it.
- R11: A transmit write that would queue into a full transmit FIFO is dropped and sets status bit 2.
- R12: In narrow mode, each read of offset 0x0 returns one 16-bit entry and removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_cs | input | 1 | Chip select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (ignored when read is also high) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| push_valid | input | 1 | Producer push request |
| push_data | input | DW | Entry to queue (32 bits wide, 16 narrow) |
| push_full | output | 1 | Receive FIFO full |
| rx_level | output | CW | Receive occupancy |
| tx_pop | input | 1 | Consumer removes transmit head |
| tx_data | output | DW | Transmit head entry |
| tx_empty | output | 1 | Transmit FIFO empty |

## Verification
Every bus read has its result on `bus_rdata` one edge after the strobe is sampled. The scoreboard monitor therefore records the strobe at the rising edge and compares at the following falling edge. One check also confirms that the old value is still present before that edge. Pushes, pops and status changes take effect at that same edge, so occupancy, full and transmit-head checks are made at the falling edge after the driving task releases its strobe. Empty-read, overflow and out-of-window cases are checked by reading status or data back through the bus.

// File: rtl/fifo_read_window.sv
module fifo_read_window #(
  parameter int          ADDR_W = 8,
  parameter logic [7:0]  BASE   = 8'h40,
  parameter int          DEPTH  = 16,
  parameter bit          WIDE   = 1'b1,
  parameter bit          TX_EN  = 1'b1,
  localparam int         DW     = WIDE ? 32 : 16,
  localparam int         AW     = $clog2(DEPTH),
  localparam int         CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_cs,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              push_valid,
  input  logic [DW-1:0]     push_data,
  output logic              push_full,
  output logic [CW-1:0]     rx_level,
  input  logic              tx_pop,
  output logic [DW-1:0]     tx_data,
  output logic              tx_empty
);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [ADDR_W-1:0] base_a;
  assign base_a = ADDR_W'(BASE);

  logic hit, rd_op, wr_op;
  logic sel_rlo, sel_rhi, sel_tlo, sel_thi, sel_st;
  assign hit     = bus_cs && !bus_addr[0] && (bus_addr[ADDR_W-1:5] == base_a[ADDR_W-1:5]);
  assign rd_op   = hit && bus_rd;
  assign wr_op   = hit && bus_wr && !bus_rd;
  assign sel_rlo = bus_addr[4:1] == 4'd0;
  assign sel_rhi = bus_addr[4:1] == 4'd1;
  assign sel_tlo = bus_addr[4:1] == 4'd2;
  assign sel_thi = bus_addr[4:1] == 4'd3;
  assign sel_st  = bus_addr[4:1] == 4'd4;

  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] rx_rp, rx_wp;
  logic [CW-1:0] rx_cnt;
  logic          rx_empty, rx_full, push_ok, rx_data_rd, rx_pop;
  logic          rx_udf, rx_ovf, tx_ovf, tx_ovf_set;
  logic [31:0]   head32;

  assign rx_empty   = rx_cnt == '0;
  assign rx_full    = rx_cnt == CW'(DEPTH);
  assign push_ok    = push_valid && !rx_full;
  assign rx_data_rd = rd_op && (sel_rlo || (WIDE && sel_rhi));
  assign rx_pop     = rx_data_rd && !rx_empty && (WIDE ? sel_rhi : 1'b1);
  assign head32     = 32'(rx_mem[rx_rp]);
  assign push_full  = rx_full;
  assign rx_level   = rx_cnt;

  always_ff @(posedge clk)
    if (push_ok) rx_mem[rx_wp] <= push_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rp  <= '0;
      rx_wp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (push_ok) rx_wp <= step(rx_wp);
      if (rx_pop)  rx_rp <= step(rx_rp);
      rx_cnt <= rx_cnt + CW'(push_ok) - CW'(rx_pop);
    end
  end

  logic [15:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (sel_rlo)                rd_val = rx_empty ? 16'h0 : head32[15:0];
    else if (sel_rhi && WIDE)   rd_val = rx_empty ? 16'h0 : head32[31:16];
    else if (sel_st)            rd_val = {13'h0, tx_ovf, rx_ovf, rx_udf};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_op) bus_rdata <= rd_val;
  end

  logic st_wr;
  assign st_wr = wr_op && sel_st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_udf <= 1'b0;
      rx_ovf <= 1'b0;
      tx_ovf <= 1'b0;
    end else begin
      if (rx_data_rd && rx_empty)       rx_udf <= 1'b1;
      else if (st_wr && bus_wdata[0])   rx_udf <= 1'b0;
      if (push_valid && rx_full)        rx_ovf <= 1'b1;
      else if (st_wr && bus_wdata[1])   rx_ovf <= 1'b0;
      if (tx_ovf_set)                   tx_ovf <= 1'b1;
      else if (st_wr && bus_wdata[2])   tx_ovf <= 1'b0;
    end
  end

  generate
    if (TX_EN) begin : g_tx
      logic [DW-1:0] tx_mem [DEPTH];
      logic [AW-1:0] tx_rp, tx_wp;
      logic [CW-1:0] tx_cnt;
      logic [15:0]   stage_lo;
      logic [31:0]   word32;
      logic          tx_push, tx_ok, tx_take;

      assign tx_push    = wr_op && (WIDE ? sel_thi : sel_tlo);
      assign tx_ok      = tx_push && (tx_cnt != CW'(DEPTH));
      assign tx_take    = tx_pop && (tx_cnt != '0);
      assign tx_ovf_set = tx_push && (tx_cnt == CW'(DEPTH));
      assign word32     = WIDE ? {bus_wdata, stage_lo} : {16'h0, bus_wdata};
      assign tx_data    = tx_mem[tx_rp];
      assign tx_empty   = tx_cnt == '0;

      always_ff @(posedge clk) begin
        if (tx_ok) tx_mem[tx_wp] <= word32[DW-1:0];
        if (wr_op && sel_tlo) stage_lo <= bus_wdata;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tx_rp  <= '0;
          tx_wp  <= '0;
          tx_cnt <= '0;
        end else begin
          if (tx_ok)   tx_wp <= step(tx_wp);
          if (tx_take) tx_rp <= step(tx_rp);
          tx_cnt <= tx_cnt + CW'(tx_ok) - CW'(tx_take);
        end
      end
    end else begin : g_no_tx
      assign tx_ovf_set = 1'b0;
      assign tx_data    = '0;
      assign tx_empty   = 1'b1;
    end
  endgenerate

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_full && !rx_pop) |=> (rx_cnt == $past(rx_cnt)) && rx_ovf);

  assert_low_read_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (WIDE && rd_op && sel_rlo && !push_valid) |=> $stable(rx_cnt));

  assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data_rd && rx_empty) |=> (bus_rdata == 16'h0) && rx_udf);

  assert_pop_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !push_valid) |=> rx_cnt == $past(rx_cnt) - 1'b1);

  assert_outside_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |=> $stable(bus_rdata));

endmodule

// File: tb/fifo_read_window_tb.sv
module fifo_read_window_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_cs = 0, bus_rd = 0, bus_wr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] rdata, n_rdata;
  logic        push_valid = 0, n_push = 0, tx_pop = 0;
  logic [31:0] push_data = 0;
  logic [15:0] n_data = 0;
  logic        push_full, n_full, tx_empty, n_tx_empty;
  logic [2:0]  rx_level, n_level;
  logic [31:0] tx_data;
  logic [15:0] n_tx_data;

  int compared = 0, mismatched = 0;
  logic [15:0] exp_q[$];
  bit          sel_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_read_window #(.ADDR_W(8), .BASE(8'h40), .DEPTH(4), .WIDE(1'b1), .TX_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cs(bus_cs), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata), .push_valid(push_valid),
    .push_data(push_data), .push_full(push_full), .rx_level(rx_level), .tx_pop(tx_pop),
    .tx_data(tx_data), .tx_empty(tx_empty));

  fifo_read_window #(.ADDR_W(8), .BASE(8'h80), .DEPTH(4), .WIDE(1'b0), .TX_EN(1'b0)) u_nar (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cs(bus_cs), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(n_rdata), .push_valid(n_push),
    .push_data(n_data), .push_full(n_full), .rx_level(n_level), .tx_pop(1'b0),
    .tx_data(n_tx_data), .tx_empty(n_tx_empty));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [15:0] e, input bit nar, input string tag);
    @(negedge clk);
    bus_addr = a; bus_cs = 1; bus_rd = 1;
    exp_q.push_back(e); sel_q.push_back(nar); tag_q.push_back(tag);
    @(negedge clk);
    bus_cs = 0; bus_rd = 0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_cs = 1; bus_wr = 1;
    @(negedge clk);
    bus_cs = 0; bus_wr = 0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    push_valid = 1; push_data = d;
    @(negedge clk);
    push_valid = 0;
  endtask

  initial begin
    forever begin
      bit seen;
      @(posedge clk);
      seen = bus_cs && bus_rd;
      @(negedge clk);
      if (seen && exp_q.size() > 0) begin
        logic [15:0] e;
        bit nar;
        string t;
        e = exp_q.pop_front(); nar = sel_q.pop_front(); t = tag_q.pop_front();
        chk(32'(nar ? n_rdata : rdata), 32'(e), t);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(32'(rdata), 0, "R4 reset rdata");
    chk(32'(push_full), 0, "R6 reset full");
    chk(32'(rx_level), 0, "R8 reset level");
    chk(32'(tx_empty), 1, "R10 reset tx_empty");

    bus_read(8'h48, 16'h0000, 0, "R7 status clear");
    bus_read(8'h40, 16'h0000, 0, "R5 empty read zero");
    chk(32'(rx_level), 0, "R5 no pop on empty");
    bus_read(8'h48, 16'h0001, 0, "R5 underflow sticky");
    bus_write(8'h48, 16'h0000);
    bus_read(8'h48, 16'h0001, 0, "R7 zero write keeps");
    bus_write(8'h48, 16'h0001);
    bus_read(8'h48, 16'h0000, 0, "R7 one write clears");

    push(32'h1111_AAAA); push(32'h2222_BBBB); push(32'h3333_CCCC); push(32'h4444_DDDD);
    chk(32'(rx_level), 4, "R8 level after pushes");
    chk(32'(push_full), 1, "R6 full flag");
    push(32'h5555_EEEE);
    chk(32'(rx_level), 4, "R6 push dropped");
    bus_read(8'h48, 16'h0002, 0, "R6 overflow sticky");
    bus_write(8'h48, 16'h0002);
    bus_read(8'h48, 16'h0000, 0, "R7 overflow cleared");

    @(negedge clk);
    bus_addr = 8'h40; bus_cs = 1; bus_rd = 1;
    exp_q.push_back(16'hAAAA); sel_q.push_back(0); tag_q.push_back("R4 latency one edge");
    chk(32'(rdata), 0, "R4 not before edge");
    @(negedge clk);
    bus_cs = 0; bus_rd = 0;
    repeat (3) @(negedge clk);
    chk(32'(rdata), 32'hAAAA, "R4 holds value");

    bus_read(8'h40, 16'hAAAA, 0, "R3 repeat low read");
    chk(32'(rx_level), 4, "R3 low read no pop");
    bus_read(8'h42, 16'h1111, 0, "R2 high half");
    chk(32'(rx_level), 3, "R1 high read pops");
    bus_read(8'h40, 16'hBBBB, 0, "R2 low half second");
    bus_read(8'h42, 16'h2222, 0, "R1 second entry");
    bus_read(8'h62, 16'h2222, 0, "R9 other window ignored");
    bus_read(8'h43, 16'h2222, 0, "R9 odd address ignored");
    chk(32'(rx_level), 2, "R9 no pop outside");
    bus_read(8'h40, 16'hCCCC, 0, "R1 third low");
    bus_read(8'h42, 16'h3333, 0, "R1 third high");
    bus_read(8'h40, 16'hDDDD, 0, "R1 fourth low");
    bus_read(8'h42, 16'h4444, 0, "R1 fourth high");
    chk(32'(rx_level), 0, "R8 drained");
    bus_read(8'h42, 16'h0000, 0, "R5 empty high read");
    bus_read(8'h48, 16'h0001, 0, "R5 flag after high");

    bus_write(8'h44, 16'h5678);
    chk(32'(tx_empty), 1, "R10 low write stages only");
    bus_write(8'h46, 16'h1234);
    chk(tx_data, 32'h1234_5678, "R10 assembled word");
    chk(32'(tx_empty), 0, "R10 queued");
    for (int i = 1; i <= 4; i++) begin
      bus_write(8'h44, 16'(i));
      bus_write(8'h46, 16'(16'hA000 + i));
    end
    bus_read(8'h48, 16'h0005, 0, "R11 tx overflow sticky");
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
    chk(tx_data, 32'hA001_0001, "R10 pop advances");

    @(negedge clk); n_push = 1; n_data = 16'hAB01;
    @(negedge clk); n_data = 16'hAB02;
    @(negedge clk); n_push = 0;
    chk(32'(n_level), 2, "R12 narrow level");
    bus_read(8'h80, 16'hAB01, 1, "R12 narrow first");
    chk(32'(n_level), 1, "R12 narrow pops");
    bus_read(8'h80, 16'hAB02, 1, "R12 narrow second");
    chk(32'(n_level), 0, "R12 narrow drained");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule